// File: doc/BRIEF.md
# Selectable-Rate Periodic Interrupt Generator

This block raises periodic interrupt events at eight fixed rates. All eight are derived from one free-running prescaler that advances on a slow clock-enable strobe, nominally 32.768 kHz. Each rate has two bits of its own. A status bit latches every event and stays set until software clears it. An enable bit decides whether that latched event may drive the interrupt request.

The prescaler runs only while at least one of two external enables is high: the timekeeping enable or the watchdog enable. With both low, no new event can occur.

The request leaves the block together with a priority level that software programs. Only levels 1 to 6 are accepted. A small register bus holds the enables, the status and the level.

Top module: `periodic_irq_gen`

## Requirements
- R1: After a synchronous reset, the enable and status registers read 0, the level reads 1, `irq_req` is low and `irq_level` is 0.
- R2: Rate i sets status bit i one clock after the prescaler bit at position `TAP_LSB+i` goes from 0 to 1. Its period is 2^(TAP_LSB+i+1) strobes, which gives 512, 256, 128, 64, 32, 16, 8 and 4 Hz at the defaults with a 32.768 kHz strobe.
- R3: The prescaler advances by one only on clocks where `tick_en` is high. Without strobes, no status bit becomes set.
- R4: While `rtc_en` and `wdog_en` are both low, the prescaler holds and no status bit becomes set. Either enable alone is enough for it to run.
- R5: Status bits are sticky. Writing to address 1 clears every bit whose write-data bit is 1, and leaves bits written with 0 unchanged.
- R6: If a rate event and a clearing write hit the same status bit on the same clock, the bit ends set.
- R7: `irq_req` is high exactly when some status bit and its enable bit are both 1. `irq_level` carries the programmed level while `irq_req` is high, and 0 otherwise.
- R8: A write to address 2 whose bits [2:0] hold 1 to 6 loads the level. A write holding 0 or 7 leaves the previous level in place.
- R9: Register map, read combinationally on `reg_rdata`: address 0 holds the enables (bit i = rate i), address 1 the status (bit i = rate i), address 2 the level in bits [2:0], and address 3 reads 0. A write to address 0 loads the enables.
- R10: A status bit becomes set on its rate's event even when its enable bit is 0. A disabled bit does not raise `irq_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Prescaler strobe (nominally 32.768 kHz) |
| rtc_en | input | 1 | Timekeeping enable; runs the prescaler |
| wdog_en | input | 1 | Watchdog enable; runs the prescaler |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Request level, 0 when idle |

## Verification
The bench builds the block with `PRESCALE_W=8` and `TAP_LSB=0`, and keeps all eight rates. Rate 0 then fires every second strobe and rate 7 every 256 strobes, so each rate produces many events in a short run.

Rate 0 fires that often, so clearing writes regularly land on the same clock as a new event, which exercises R6. Stopped intervals and rejected level writes also fall inside the random stream.

// File: rtl/prg_pkg.sv
package prg_pkg;

    localparam int LEVEL_W = 3;

    typedef logic [LEVEL_W-1:0] irq_level_t;

    localparam irq_level_t LEVEL_RESET = 3'd1;
    localparam irq_level_t LEVEL_MIN   = 3'd1;
    localparam irq_level_t LEVEL_MAX   = 3'd6;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_LEVEL  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic en_wr;
        logic st_wr;
        logic lv_wr;
    } wr_strobe_t;

    function automatic logic level_valid(input irq_level_t v);
        return (v >= LEVEL_MIN) && (v <= LEVEL_MAX);
    endfunction

    function automatic wr_strobe_t decode_write(input logic we, input reg_sel_e sel);
        wr_strobe_t s;
        s.en_wr = we && (sel == SEL_ENABLE);
        s.st_wr = we && (sel == SEL_STATUS);
        s.lv_wr = we && (sel == SEL_LEVEL);
        return s;
    endfunction

endpackage

// File: rtl/prg_prescaler.sv
module prg_prescaler #(
    parameter int PRESCALE_W = 15,
    parameter int NUM_RATES  = 8,
    parameter int TAP_LSB    = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_en,
    input  logic                 run,
    output logic [NUM_RATES-1:0] rate_pulse
);
    localparam int TAP_MSB = TAP_LSB + NUM_RATES - 1;

    logic [PRESCALE_W-1:0] cnt_q;
    logic [NUM_RATES-1:0]  taps;
    logic [NUM_RATES-1:0]  taps_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            taps_q <= '0;
        end else begin
            taps_q <= taps;
            if (run && tick_en)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign taps = cnt_q[TAP_MSB:TAP_LSB];

    for (genvar i = 0; i < NUM_RATES; i++) begin : g_edge
        assign rate_pulse[i] = taps[i] & ~taps_q[i];
    end

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(cnt_q)); // R4
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(cnt_q)); // R3
    AST_PULSE_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
        (|rate_pulse) |-> $past(run && tick_en)); // R4

endmodule

// File: rtl/prg_status.sv
module prg_status #(
    parameter int NUM_RATES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_RATES-1:0] set_i,
    input  logic [NUM_RATES-1:0] clr_i,
    output logic [NUM_RATES-1:0] status_o
);
    logic [NUM_RATES-1:0] status_q;

    for (genvar i = 0; i < NUM_RATES; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                status_q[i] <= 1'b0;
            else if (set_i[i])
                status_q[i] <= 1'b1;
            else if (clr_i[i])
                status_q[i] <= 1'b0;
        end

        AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
            status_q[i] && !clr_i[i] |=> status_q[i]); // R5
        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> status_q[i]); // R6
        AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
            $rose(status_q[i]) |-> $past(set_i[i])); // R2
    end

    assign status_o = status_q;

endmodule

// File: rtl/prg_cfg_regs.sv
module prg_cfg_regs
    import prg_pkg::*;
#(
    parameter int NUM_RATES = 8,
    parameter int DATA_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en_wr,
    input  logic                 lv_wr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [NUM_RATES-1:0] enable_o,
    output irq_level_t           level_o
);
    logic [NUM_RATES-1:0] enable_q;
    irq_level_t           level_q;
    irq_level_t           level_in;

    assign level_in = wdata[LEVEL_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            level_q  <= LEVEL_RESET;
        end else begin
            if (en_wr)
                enable_q <= wdata[NUM_RATES-1:0];
            if (lv_wr && level_valid(level_in))
                level_q <= level_in;
        end
    end

    assign enable_o = enable_q;
    assign level_o  = level_q;

    AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (level_q >= LEVEL_MIN) && (level_q <= LEVEL_MAX)); // R8
    AST_LEVEL_REJECT: assert property (@(posedge clk) disable iff (rst)
        lv_wr && (level_in == 3'd0 || level_in == 3'd7) |=> $stable(level_q)); // R8

endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
    import prg_pkg::*;
#(
    parameter int PRESCALE_W = 15,
    parameter int NUM_RATES  = 8,
    parameter int TAP_LSB    = 5,
    localparam int DATA_W    = (NUM_RATES < LEVEL_W) ? LEVEL_W : NUM_RATES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              rtc_en,
    input  logic              wdog_en,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_req,
    output logic [2:0]        irq_level
);
    reg_sel_e             sel;
    wr_strobe_t           wr;
    logic                 run;
    logic [NUM_RATES-1:0] rate_pulse;
    logic [NUM_RATES-1:0] clr_mask;
    logic [NUM_RATES-1:0] status;
    logic [NUM_RATES-1:0] enable;
    irq_level_t           level;

    assign sel      = reg_sel_e'(reg_addr);
    assign wr       = decode_write(reg_we, sel);
    assign run      = rtc_en | wdog_en;
    assign clr_mask = wr.st_wr ? reg_wdata[NUM_RATES-1:0] : '0;

    prg_prescaler #(
        .PRESCALE_W(PRESCALE_W),
        .NUM_RATES (NUM_RATES),
        .TAP_LSB   (TAP_LSB)
    ) u_presc (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .run       (run),
        .rate_pulse(rate_pulse)
    );

    prg_status #(
        .NUM_RATES(NUM_RATES)
    ) u_status (
        .clk     (clk),
        .rst     (rst),
        .set_i   (rate_pulse),
        .clr_i   (clr_mask),
        .status_o(status)
    );

    prg_cfg_regs #(
        .NUM_RATES(NUM_RATES),
        .DATA_W   (DATA_W)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .en_wr   (wr.en_wr),
        .lv_wr   (wr.lv_wr),
        .wdata   (reg_wdata),
        .enable_o(enable),
        .level_o (level)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_ENABLE: reg_rdata[NUM_RATES-1:0] = enable;
            SEL_STATUS: reg_rdata[NUM_RATES-1:0] = status;
            SEL_LEVEL:  reg_rdata[LEVEL_W-1:0]   = level;
            SEL_NONE:   reg_rdata                = '0;
        endcase
    end

    assign irq_req   = |(status & enable);
    assign irq_level = irq_req ? level : 3'd0;

    AST_REQ_HAS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_level != 3'd0)); // R7
    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> $past((|rate_pulse) || wr.en_wr)); // R7

endmodule

// File: tb/periodic_irq_gen_tb.sv
module periodic_irq_gen_tb;

    localparam int PW = 8;
    localparam int NR = 8;
    localparam int TL = 0;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_en = 1'b0, rtc_en = 1'b0, wdog_en = 1'b0, reg_we = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          irq_req;
    logic [2:0]    irq_level;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_tag = "R1";

    logic [PW-1:0] m_pre;
    logic [NR-1:0] m_tq, m_st, m_en;
    logic [2:0]    m_lvl;

    always #2.5 clk = ~clk;

    periodic_irq_gen #(.PRESCALE_W(PW), .NUM_RATES(NR), .TAP_LSB(TL)) u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .rtc_en(rtc_en), .wdog_en(wdog_en),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_level(irq_level)
    );

    function automatic logic [NR-1:0] f_taps(input logic [PW-1:0] p);
        return p[TL +: NR];
    endfunction

    function automatic logic [DW-1:0] f_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_en;
            2'd1:    return m_st;
            2'd2:    return {5'd0, m_lvl};
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", cur_tag, what, got, exp);
        end
    endtask

    task automatic compare_all();
        logic ei;
        ei = |(m_st & m_en);
        chk("irq_req (R7)", 32'(irq_req), 32'(ei));
        chk("irq_level (R7)", 32'(irq_level), 32'(ei ? m_lvl : 3'd0));
        chk("reg_rdata (R9)", 32'(reg_rdata), 32'(f_read(reg_addr)));
    endtask

    task automatic step(input logic tk, input logic rc, input logic wd,
                        input logic we, input logic [1:0] a, input logic [DW-1:0] d);
        logic [NR-1:0] set_v, clr_v;
        @(negedge clk);
        tick_en = tk; rtc_en = rc; wdog_en = wd;
        reg_we = we; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        set_v = f_taps(m_pre) & ~m_tq;
        m_tq  = f_taps(m_pre);
        if (tk && (rc || wd)) m_pre = m_pre + 1'b1;
        clr_v = (we && a == 2'd1) ? d[NR-1:0] : '0;
        m_st  = (m_st & ~clr_v) | set_v;
        if (we && a == 2'd0) m_en = d[NR-1:0];
        if (we && a == 2'd2 && d[2:0] >= 3'd1 && d[2:0] <= 3'd6) m_lvl = d[2:0];
        #1;
        compare_all();
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_pre = '0; m_tq = '0; m_st = '0; m_en = '0; m_lvl = 3'd1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset values through the register map
        cur_tag = "R1";
        for (int a = 0; a < 4; a++) begin
            reg_addr = 2'(a);
            #0.5;
            chk("reset read (R1)", 32'(reg_rdata), 32'(f_read(2'(a))));
        end
        chk("reset irq_req (R1)", 32'(irq_req), 32'd0);
        chk("reset irq_level (R1)", 32'(irq_level), 32'd0);

        // R8: legal and illegal level writes
        cur_tag = "R8";
        step(0, 0, 0, 1, 2'd2, 8'h03);
        chk("level after 3 (R8)", 32'(reg_rdata[2:0]), 32'd3);
        step(0, 0, 0, 1, 2'd2, 8'h00);
        chk("level after 0 (R8)", 32'(reg_rdata[2:0]), 32'd3);
        step(0, 0, 0, 1, 2'd2, 8'hF7);
        chk("level after 7 (R8)", 32'(reg_rdata[2:0]), 32'd3);
        step(0, 0, 0, 1, 2'd2, 8'h06);
        chk("level after 6 (R8)", 32'(reg_rdata[2:0]), 32'd6);

        // R10: events latch while disabled, no request
        cur_tag = "R10";
        for (int i = 0; i < 40; i++) step(1, 1, 0, 0, 2'd1, 8'h00);
        chk("status latched while disabled (R10)", 32'(reg_rdata != 0), 32'd1);
        chk("no request while disabled (R10)", 32'(irq_req), 32'd0);

        // R7: enabling raises request
        cur_tag = "R7";
        step(0, 1, 0, 1, 2'd0, 8'hFF);
        chk("request after enable (R7)", 32'(irq_req), 32'd1);

        // R5: writing 0 keeps, writing 1 clears
        cur_tag = "R5";
        step(0, 1, 0, 1, 2'd1, 8'h00);
        step(0, 1, 0, 1, 2'd1, 8'hFF);
        chk("status cleared (R5)", 32'(reg_rdata), 32'd0);

        // R3: no strobe, no events
        cur_tag = "R3";
        for (int i = 0; i < 30; i++) step(0, 1, 1, 0, 2'd1, 8'h00);
        chk("status idle without strobe (R3)", 32'(reg_rdata), 32'd0);

        // R4: both enables low stops events; each one alone runs
        cur_tag = "R4";
        for (int i = 0; i < 300; i++) step(1, 0, 0, 0, 2'd1, 8'h00);
        chk("status idle when stopped (R4)", 32'(reg_rdata), 32'd0);
        for (int i = 0; i < 4; i++) step(1, 0, 1, 0, 2'd1, 8'h00);
        step(1, 1, 0, 1, 2'd1, 8'hFF);
        for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 2'd1, 8'h00);

        // R6: clear every cycle against frequent rate-0 events
        cur_tag = "R6";
        for (int i = 0; i < 64; i++) step(1, 1, 0, 1, 2'd1, 8'hFF);

        // R9: read every address
        cur_tag = "R9";
        for (int a = 0; a < 4; a++) step(1, 0, 1, 0, 2'(a), 8'h00);

        // R2: random mix, rate timing checked each cycle
        cur_tag = "R2";
        for (int i = 0; i < 15000; i++) begin
            step(($urandom % 4) != 0, ($urandom % 8) != 0, ($urandom % 2) == 1,
                 ($urandom % 6) == 0, 2'($urandom % 4), 8'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule